// File: doc/BRIEF.md
# Top-Bit Predicted Registered Magnitude Comparator

This block compares two unsigned N-bit operands and reports, through an output register, whether the first operand is strictly greater than the second. Its purpose is to cut switching activity inside the comparator. A small predictor looks only at the two most significant bits of the operands arriving in the current cycle. When those two bits differ, the answer is already fixed by them alone. In that case the register that carries the lower-order bits keeps its old contents, and fewer comparator inputs toggle.

The top bits of both operands sit in a register of their own that loads on every edge. The comparator therefore always works from the correct top-bit pair. When the top bits differ, any stale lower bits cannot change the outcome. When the top bits are equal, the lower bits are loaded fresh.

A two-state machine tracks the lower-bit register. In state `LO_TRACK` the register loaded on the last edge. In state `LO_HOLD` it was frozen on the last edge. The machine has these transitions:
- `TRACK_TO_HOLD` and `HOLD_TO_HOLD` are taken when the sampled top bits differ.
- `HOLD_TO_TRACK` and `TRACK_TO_TRACK` are taken when the sampled top bits are equal.

The load enable of the lower-bit register is decoded from the next state. A free-running counter totals the edges on which the register was held, so that the hold ratio can be measured over a workload.

Top module: `msb_gated_cmp`

## Requirements
- R1: `gt_out` equals 1 exactly when unsigned `c_in` is greater than unsigned `d_in`, for the operands sampled two rising edges earlier, for any operand stream.
- R2: A synchronous active-high `rst` clears `gt_out`, `lo_held`, `hold_cnt` and all internal operand registers to zero on the next edge. The state machine returns to `LO_TRACK`.
- R3: When the sampled operands have `c_in[N-1]`=1 and `d_in[N-1]`=0, `gt_out` is 1 two edges later, whatever the lower bits are. `lo_held` is 1 after the sampling edge.
- R4: When the sampled operands have `c_in[N-1]`=0 and `d_in[N-1]`=1, `gt_out` is 0 two edges later, whatever the lower bits are. `lo_held` is 1 after the sampling edge.
- R5: When the sampled top bits are equal, the lower-bit register loads bits N-2..0 of both operands, and `lo_held` is 0 after that edge.
- R6: `hold_cnt` rises by exactly one on each non-reset edge whose sampled top bits differ. It is unchanged on every other non-reset edge, and it wraps modulo 2^CW.
- R7: Equal operands give `gt_out` = 0, including all-zero and all-one operands.
- R8: Lower bits frozen on a held edge never leak into a later result. Once the top bits become equal again, the result reflects the new lower bits.
- R9: The extreme operand pairs are compared correctly: all-ones against all-zeros gives 1, all-zeros against all-ones gives 0, and all-ones against all-ones minus one gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| c_in | input | N | First operand, unsigned |
| d_in | input | N | Second operand, unsigned |
| gt_out | output | 1 | Registered result of c > d, two edges after sampling |
| lo_held | output | 1 | 1 when the lower-bit register was frozen on the last edge (state LO_HOLD) |
| hold_cnt | output | CW | Number of edges on which the lower-bit register was frozen |

## Verification
The comparison result lands in `gt_out` on the second rising edge after an operand pair is sampled. The `lo_held` flag and the `hold_cnt` counter follow on the first edge. The bench drives operands on the falling edge. It reads `lo_held` and `hold_cnt` at the falling edge after one rising edge, and `gt_out` at the falling edge after the second. In the streaming test a new pair is driven every cycle, and each result is compared with the pair from two cycles before. The expected hold count is accumulated per rising edge from the top bits the bench itself drove.

// File: rtl/msb_gated_cmp_pkg.sv
package msb_gated_cmp_pkg;

    // State of the lower-bit operand register after the most recent edge
    typedef enum logic {
        LO_TRACK = 1'b0,
        LO_HOLD  = 1'b1
    } lo_mode_e;

endpackage

// File: rtl/msb_gated_cmp_predict.sv
module msb_gated_cmp_predict (
    input  logic c_top,
    input  logic d_top,
    output logic g_one,
    output logic g_zero
);
    // g_one: top bits alone force c > d. g_zero: top bits alone force c <= d.
    always_comb begin
        g_one  = c_top & ~d_top;
        g_zero = ~c_top & d_top;
    end
endmodule

// File: rtl/msb_gated_cmp_opreg.sv
module msb_gated_cmp_opreg #(
    parameter int N = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lo_load,
    input  logic [N-1:0]  c_in,
    input  logic [N-1:0]  d_in,
    output logic          c_top_q,
    output logic          d_top_q,
    output logic [N-2:0]  lo_c_q,
    output logic [N-2:0]  lo_d_q
);
    localparam int LW = N - 1;

    // Top-bit pair: loads on every edge
    always_ff @(posedge clk) begin
        if (rst) begin
            c_top_q <= 1'b0;
            d_top_q <= 1'b0;
        end else begin
            c_top_q <= c_in[N-1];
            d_top_q <= d_in[N-1];
        end
    end

    // Lower-order bits: load only when enabled
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_c_q <= '0;
            lo_d_q <= '0;
        end else if (lo_load) begin
            lo_c_q <= c_in[LW-1:0];
            lo_d_q <= d_in[LW-1:0];
        end
    end
endmodule

// File: rtl/msb_gated_cmp_mag.sv
module msb_gated_cmp_mag #(
    parameter int N = 16
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic         a_gt_b
);
    // Walk from the top bit down. The first differing bit decides.
    always_comb begin
        logic still_eq;
        a_gt_b   = 1'b0;
        still_eq = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            a_gt_b   = a_gt_b | (still_eq & a[i] & ~b[i]);
            still_eq = still_eq & ~(a[i] ^ b[i]);
        end
    end
endmodule

// File: rtl/msb_gated_cmp.sv
module msb_gated_cmp
    import msb_gated_cmp_pkg::*;
#(
    parameter int N  = 16,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  c_in,
    input  logic [N-1:0]  d_in,
    output logic          gt_out,
    output logic          lo_held,
    output logic [CW-1:0] hold_cnt
);
    localparam int LW = N - 1;

    lo_mode_e        mode_q, mode_d;
    logic            g_one, g_zero;
    logic            lo_load;
    logic            c_top_q, d_top_q;
    logic [LW-1:0]   lo_c_q, lo_d_q;
    logic            cmp_gt;

    // Predictor looks at the incoming operands only
    msb_gated_cmp_predict u_pred (
        .c_top  (c_in[N-1]),
        .d_top  (d_in[N-1]),
        .g_one  (g_one),
        .g_zero (g_zero)
    );

    // Next-state selection
    always_comb begin
        unique case ({g_one, g_zero})
            2'b10, 2'b01: mode_d = LO_HOLD;
            default:      mode_d = LO_TRACK;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) mode_q <= LO_TRACK;
        else     mode_q <= mode_d;
    end

    // Outputs decoded from the states
    always_comb begin
        lo_load = (mode_d == LO_TRACK);
        lo_held = (mode_q == LO_HOLD);
    end

    msb_gated_cmp_opreg #(.N(N)) u_ops (
        .clk     (clk),
        .rst     (rst),
        .lo_load (lo_load),
        .c_in    (c_in),
        .d_in    (d_in),
        .c_top_q (c_top_q),
        .d_top_q (d_top_q),
        .lo_c_q  (lo_c_q),
        .lo_d_q  (lo_d_q)
    );

    msb_gated_cmp_mag #(.N(N)) u_mag (
        .a      ({c_top_q, lo_c_q}),
        .b      ({d_top_q, lo_d_q}),
        .a_gt_b (cmp_gt)
    );

    // Result register
    always_ff @(posedge clk) begin
        if (rst) gt_out <= 1'b0;
        else     gt_out <= cmp_gt;
    end

    // Held-edge counter
    always_ff @(posedge clk) begin
        if (rst)                    hold_cnt <= '0;
        else if (mode_d == LO_HOLD) hold_cnt <= hold_cnt + CW'(1);
    end
endmodule

// File: rtl/msb_gated_cmp_chk.sv
module msb_gated_cmp_chk #(
    parameter int N  = 16,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  c_in,
    input logic [N-1:0]  d_in,
    input logic          gt_out,
    input logic          lo_held,
    input logic [CW-1:0] hold_cnt,
    input logic          g_one,
    input logic          g_zero,
    input logic [N-2:0]  lo_c_q,
    input logic [N-2:0]  lo_d_q
);
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)              warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    p_result_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (gt_out == ($past(c_in, 2) > $past(d_in, 2))));

    p_reset_clears_r2: assert property (@(posedge clk)
        rst |=> (gt_out == 1'b0 && lo_held == 1'b0 && hold_cnt == '0));

    p_pred_sound_r3: assert property (@(posedge clk) disable iff (rst)
        g_one |-> (c_in > d_in));

    p_pred_sound_r4: assert property (@(posedge clk) disable iff (rst)
        g_zero |-> !(c_in > d_in));

    p_hold_freezes_r3: assert property (@(posedge clk) disable iff (rst)
        (c_in[N-1] != d_in[N-1]) |=> ($stable(lo_c_q) && $stable(lo_d_q) && lo_held));

    p_track_loads_r5: assert property (@(posedge clk) disable iff (rst)
        (c_in[N-1] == d_in[N-1]) |=>
            (lo_c_q == $past(c_in[N-2:0]) && lo_d_q == $past(d_in[N-2:0]) && !lo_held));

    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (hold_cnt == $past(hold_cnt) + CW'($past(c_in[N-1] != d_in[N-1]))));

    p_pred_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        $countones({g_one, g_zero}) <= 1);
endmodule

bind msb_gated_cmp msb_gated_cmp_chk #(.N(N), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .c_in     (c_in),
    .d_in     (d_in),
    .gt_out   (gt_out),
    .lo_held  (lo_held),
    .hold_cnt (hold_cnt),
    .g_one    (g_one),
    .g_zero   (g_zero),
    .lo_c_q   (lo_c_q),
    .lo_d_q   (lo_d_q)
);

// File: tb/sim_msb_gated_cmp.sv
`timescale 1ns/1ps
module sim_msb_gated_cmp;
    localparam int N  = 16;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  c_r = '0;
    logic [N-1:0]  d_r = '0;
    logic          gt_out;
    logic          lo_held;
    logic [CW-1:0] hold_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    msb_gated_cmp #(.N(N), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .c_in(c_r), .d_in(d_r),
        .gt_out(gt_out), .lo_held(lo_held), .hold_cnt(hold_cnt)
    );

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (c=%h d=%h)", req, act, exp, c_r, d_r);
        end
    endtask

    // One rising edge, then land on the falling edge; counts expected holds
    task automatic tick();
        @(posedge clk);
        if (rst) exp_cnt = 0;
        else if (c_r[N-1] != d_r[N-1]) exp_cnt++;
        @(negedge clk);
    endtask

    // Drive one pair and check all three results at their due cycles
    task automatic apply_pair(input logic [N-1:0] c, input logic [N-1:0] d, input string req);
        c_r = c; d_r = d;
        tick();
        check(req, CW'(lo_held), CW'(c[N-1] != d[N-1]));
        check("R6", hold_cnt, CW'(exp_cnt));
        tick();
        check(req, CW'(gt_out), CW'(c > d));
    endtask

    task automatic t_reset();
        rst = 1'b1; c_r = 16'hFFFF; d_r = 16'h0000;
        tick(); tick();
        check("R2", CW'(gt_out), 0);
        check("R2", CW'(lo_held), 0);
        check("R2", hold_cnt, 0);
        rst = 1'b0;
    endtask

    task automatic t_msb_decides();
        apply_pair(16'h8000, 16'h7FFF, "R3");
        apply_pair(16'h8123, 16'h0FFF, "R3");
        apply_pair(16'h7FFF, 16'h8000, "R4");
        apply_pair(16'h0000, 16'hFFFE, "R4");
    endtask

    task automatic t_low_decides();
        apply_pair(16'h1235, 16'h1234, "R5");
        apply_pair(16'h1234, 16'h1235, "R5");
        apply_pair(16'hC001, 16'hC000, "R5");
    endtask

    task automatic t_equal();
        apply_pair(16'h0000, 16'h0000, "R7");
        apply_pair(16'hFFFF, 16'hFFFF, "R7");
        apply_pair(16'h5A5A, 16'h5A5A, "R7");
    endtask

    task automatic t_stale();
        apply_pair(16'h7FFF, 16'h0000, "R8");   // loads low 7FFF / 0000
        apply_pair(16'h8000, 16'h7FFF, "R8");   // held; stale low kept
        apply_pair(16'h0001, 16'h0002, "R8");   // stale low would say 1
        apply_pair(16'h8000, 16'h0000, "R8");
        apply_pair(16'h0003, 16'h0002, "R8");
    endtask

    task automatic t_extremes();
        apply_pair(16'hFFFF, 16'h0000, "R9");
        apply_pair(16'h0000, 16'hFFFF, "R9");
        apply_pair(16'hFFFF, 16'hFFFE, "R9");
        apply_pair(16'hFFFE, 16'hFFFF, "R9");
    endtask

    task automatic t_stream();
        logic [N-1:0] hc [0:1];
        logic [N-1:0] hd [0:1];
        int start_cnt;
        int held;
        start_cnt = exp_cnt;
        for (int k = 0; k < 400; k++) begin
            hc[1] = hc[0]; hd[1] = hd[0];
            hc[0] = c_r;   hd[0] = d_r;
            c_r = N'($urandom);
            d_r = N'($urandom);
            if (k % 7 == 0) d_r = c_r;
            tick();
            if (k >= 2) check("R1", CW'(gt_out), CW'(hc[0] > hd[0]));
        end
        check("R6", hold_cnt, CW'(exp_cnt));
        held = exp_cnt - start_cnt;
        check("R6", CW'(held > 120 && held < 280), 1);
    endtask

    task automatic t_mid_reset();
        apply_pair(16'h9000, 16'h1000, "R3");
        rst = 1'b1;
        tick();
        check("R2", CW'(gt_out), 0);
        check("R2", hold_cnt, 0);
        check("R2", CW'(lo_held), 0);
        rst = 1'b0;
        apply_pair(16'h0002, 16'h0001, "R2");
    endtask

    initial begin
        void'($urandom(32'h1D5));
        @(negedge clk);
        t_reset();
        t_msb_decides();
        t_low_decides();
        t_equal();
        t_stale();
        t_extremes();
        t_stream();
        t_mid_reset();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule